// File: doc/BRIEF.md
# E1 Transmit Payload Selector with Loopback Elastic Store

This block chooses what the transmit side of a 2.048 Mbit/s E1 framer sends, one byte per transmit strobe. In normal mode it forwards the local transmit byte stream. The signalling byte takes the place of time slot 16, and a local sync strobe fixes the slot count. In payload loopback mode the recovered receive bytes pass through a two-frame elastic store and go back out. The local data, signalling, sync and multiframe-sync inputs then have no effect.

Time slot 0 of the looped stream is either carried through unchanged or replaced by a locally generated framing word. The framing word alternates between the alignment word and the non-alignment word on successive frames. An alarm input forces all ones onto any byte that it accompanies.

The write side and the read side of the store advance on their own frame-aligned strobes. At each read frame start the block judges how far apart the two pointers are. When they are about to cross, it repeats or skips a whole frame. Any control write moves the read pointer back to about half the depth behind the write pointer, keeping its slot phase. This forces one controlled slip.

Top module: `payload_loop_tx`

## Requirements
- R1: With loopback off, each tx_vld produces one out_vld pulse on the next cycle. out_byte is tx_sig when the local slot count is 16 and tx_byte otherwise. out_ts is the local slot count: 0 when tx_sync accompanies tx_vld, otherwise the previous value plus one, modulo 32. out_mfs copies tx_mfs.
- R2: With loopback on, out_byte carries bytes read from the elastic store, and out_mfs is 0. tx_byte, tx_sig, tx_sync and tx_mfs have no effect on any output.
- R3: With loopback on and ctrl_ts0_thru at 1, time slot 0 (read address slot bits equal to 0) is looped like any other slot.
- R4: With loopback on and ctrl_ts0_thru at 0, time slot 0 is replaced by 0x1B or 0x40. A frame-parity bit selects 0x1B when it is 0. The bit is 0 after reset and toggles at every read of slot 0, whatever the mode.
- R5: ais_force sampled with tx_vld makes that output byte 0xFF in either mode. out_ts and out_mfs are unaffected.
- R6: A cycle with ctrl_wr loads ctrl_loop and ctrl_ts0_thru; the new settings apply from the next cycle. In the same cycle the read pointer is reloaded so that the write-minus-read distance lies in 16..47, keeping the read slot bits.
- R7: When a transmit strobe reads slot 0, the write-minus-read distance (6 bits) is checked first. Below 2, the read address moves back 32 (frame repeated) and slip_rep pulses. Above 62, it moves ahead 32 (frame dropped) and slip_drop pulses. Both pulses appear with the output byte of that strobe.
- R8: rx_vld writes rx_byte at the write pointer and advances it by one. With rx_fs, the write address first moves to slot 0 of the next frame, unless it is already at slot 0.
- R9: Reset leaves out_vld, out_byte, out_ts, out_mfs and both slip pulses at 0, the store contents at 0, the read pointer at 0 and the write pointer at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Recovered receive byte |
| rx_vld | input | 1 | Receive byte strobe |
| rx_fs | input | 1 | Receive byte is time slot 0 |
| tx_byte | input | 8 | Local transmit byte |
| tx_sig | input | 8 | Local signalling byte for slot 16 |
| tx_vld | input | 1 | Transmit byte strobe (read strobe) |
| tx_sync | input | 1 | Local transmit byte is time slot 0 |
| tx_mfs | input | 1 | Local multiframe start marker |
| ctrl_wr | input | 1 | Control register write pulse |
| ctrl_loop | input | 1 | Loopback enable written by ctrl_wr |
| ctrl_ts0_thru | input | 1 | Loop slot 0 (1) or generate it (0) |
| ais_force | input | 1 | Force all-ones output byte |
| out_byte | output | 8 | Transmit payload byte |
| out_vld | output | 1 | out_byte valid pulse |
| out_ts | output | 5 | Slot index of out_byte |
| out_mfs | output | 1 | Multiframe marker with out_byte |
| slip_rep | output | 1 | Frame repeated at this read |
| slip_drop | output | 1 | Frame dropped at this read |

## Verification
A read pointer that is off by any amount shows on the very next loopback strobe. The byte differs from the one the reference wrote at that address, and out_ts shows a shifted slot phase. A write pointer misplaced by a wrong alignment on rx_fs shows as soon as the affected frame is read back, at most two frames later. A wrong parity bit swaps 0x1B and 0x40 at the next generated slot 0. A wrong distance judgement moves a slip pulse to another frame start, where the per-clock comparison against the behavioural model catches it.

// File: rtl/plt_pkg.sv
package plt_pkg;

  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DROP   = 2'd2
  } slip_e;

  // Next frame start for a write address, unless already on one.
  function automatic int frame_align(int p, int frame, int depth);
    if (p % frame == 0) return p;
    return (((p / frame) + 1) * frame) % depth;
  endfunction

  // Verdict on the write-minus-read separation at a read frame start.
  function automatic slip_e slip_judge(int sep, int guard, int depth);
    if (sep < guard) return SLIP_REPEAT;
    if (sep > depth - guard) return SLIP_DROP;
    return SLIP_NONE;
  endfunction

  // Read pointer placed near half depth behind wr, same slot phase as rd.
  function automatic int centre_rd(int wr, int rd, int frame, int depth);
    int phase;
    int lift;
    int target;
    phase  = ((wr - rd) % frame + frame) % frame;
    lift   = (depth / 2 - phase + frame / 2 - 1) / frame;
    target = phase + lift * frame;
    return (wr - target + depth) % depth;
  endfunction

endpackage

// File: rtl/plt_wr_ctl.sv
module plt_wr_ctl #(
  parameter int FRAME_SLOTS = 32,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_fs,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] wr_next
);
  import plt_pkg::*;

  always_comb begin
    wr_en   = rx_vld;
    wr_addr = rx_fs ? PTR_W'(frame_align(int'(wr_ptr), FRAME_SLOTS, DEPTH)) : wr_ptr;
    wr_next = rx_vld ? wr_addr + PTR_W'(1) : wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ptr <= PTR_W'(DEPTH / 2);
    else        wr_ptr <= wr_next;
  end

  // R8
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && rx_fs) |=> (wr_ptr[SLOT_W-1:0] == SLOT_W'(1)));

  // R8
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_vld) |=> $stable(wr_ptr));

endmodule

// File: rtl/plt_buf.sv
module plt_buf #(
  parameter int W = 8,
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Read sees the contents before this cycle's write.
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

endmodule

// File: rtl/plt_rd_ctl.sv
module plt_rd_ctl #(
  parameter int FRAME_SLOTS = 32,
  parameter int DEPTH = 64,
  parameter int GUARD = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_vld,
  input  logic              ctrl_wr,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  wr_next,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              slip_rep,
  output logic              slip_drop
);
  import plt_pkg::*;

  localparam logic [PTR_W-1:0] FRAME_STEP = PTR_W'(FRAME_SLOTS);
  localparam logic [PTR_W-1:0] CEN_LO     = PTR_W'(FRAME_SLOTS / 2);
  localparam logic [PTR_W-1:0] CEN_HI     = PTR_W'(DEPTH / 2 + FRAME_SLOTS / 2 - 1);
  localparam logic [PTR_W-1:0] POST_HI    = PTR_W'(DEPTH - FRAME_SLOTS / 2);

  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] sep;
  logic [PTR_W-1:0] rd_after;
  logic [PTR_W-1:0] rd_load;
  slip_e            verdict;

  always_comb begin
    sep     = wr_ptr - rd_ptr;
    verdict = SLIP_NONE;
    if (tx_vld && rd_ptr[SLOT_W-1:0] == '0)
      verdict = slip_judge(int'(sep), GUARD, DEPTH);
    unique case (verdict)
      SLIP_REPEAT: rd_addr = rd_ptr - FRAME_STEP;
      SLIP_DROP:   rd_addr = rd_ptr + FRAME_STEP;
      default:     rd_addr = rd_ptr;
    endcase
    rd_slot  = rd_addr[SLOT_W-1:0];
    rd_after = tx_vld ? rd_addr + PTR_W'(1) : rd_ptr;
    rd_load  = ctrl_wr ? PTR_W'(centre_rd(int'(wr_next), int'(rd_after), FRAME_SLOTS, DEPTH))
                       : rd_after;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      slip_rep  <= 1'b0;
      slip_drop <= 1'b0;
    end else begin
      rd_ptr    <= rd_load;
      slip_rep  <= (verdict == SLIP_REPEAT);
      slip_drop <= (verdict == SLIP_DROP);
    end
  end

  // R7
  slip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slip_rep, slip_drop}));

  // R7
  slip_heal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_rep || slip_drop) |-> (sep >= CEN_LO && sep <= POST_HI));

  // R6
  centre_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (sep >= CEN_LO && sep <= CEN_HI));

  // R6
  centre_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !tx_vld) |=> (rd_ptr[SLOT_W-1:0] == $past(rd_ptr[SLOT_W-1:0])));

endmodule

// File: rtl/plt_tx_mux.sv
module plt_tx_mux #(
  parameter int W = 8,
  parameter int FRAME_SLOTS = 32,
  parameter int SIG_SLOT = 16,
  parameter logic [W-1:0] FAS_WORD = 8'h1B,
  parameter logic [W-1:0] NFAS_WORD = 8'h40,
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_vld,
  input  logic [W-1:0]      tx_byte,
  input  logic [W-1:0]      tx_sig,
  input  logic              tx_sync,
  input  logic              tx_mfs,
  input  logic              ais_force,
  input  logic              loop_q,
  input  logic              thru_q,
  input  logic [W-1:0]      buf_byte,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [W-1:0]      out_byte,
  output logic              out_vld,
  output logic [SLOT_W-1:0] out_ts,
  output logic              out_mfs
);
  logic [SLOT_W-1:0] ts_cnt;
  logic [SLOT_W-1:0] n_slot;
  logic              fpar;
  logic [W-1:0]      pick;
  logic              gen_ts0;

  always_comb begin
    n_slot  = tx_sync ? '0 : ts_cnt;
    gen_ts0 = loop_q && !thru_q && (rd_slot == '0);
    if (ais_force)    pick = '1;
    else if (gen_ts0) pick = fpar ? NFAS_WORD : FAS_WORD;
    else if (loop_q)  pick = buf_byte;
    else if (n_slot == SLOT_W'(SIG_SLOT)) pick = tx_sig;
    else              pick = tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_cnt   <= '0;
      fpar     <= 1'b0;
      out_byte <= '0;
      out_vld  <= 1'b0;
      out_ts   <= '0;
      out_mfs  <= 1'b0;
    end else begin
      out_vld <= tx_vld;
      if (tx_vld) begin
        ts_cnt   <= n_slot + SLOT_W'(1);
        if (rd_slot == '0) fpar <= ~fpar;
        out_byte <= pick;
        out_ts   <= loop_q ? rd_slot : n_slot;
        out_mfs  <= !loop_q && tx_mfs;
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |=> out_vld);

  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld |=> !out_vld);

  // R5
  ais_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && ais_force) |=> (out_byte == '1));

  // R2
  loop_mfs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && loop_q) |=> !out_mfs);

  // R4
  gen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_vld && loop_q && !thru_q && !ais_force && rd_slot == '0)
      |=> (out_byte == FAS_WORD || out_byte == NFAS_WORD));

endmodule

// File: rtl/payload_loop_tx.sv
module payload_loop_tx #(
  parameter int W = 8,
  parameter int FRAME_SLOTS = 32,
  parameter int DEPTH_FRAMES = 2,
  parameter int GUARD = 2,
  parameter int SIG_SLOT = 16,
  parameter logic [W-1:0] FAS_WORD = 8'h1B,
  parameter logic [W-1:0] NFAS_WORD = 8'h40,
  localparam int DEPTH = FRAME_SLOTS * DEPTH_FRAMES,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      rx_byte,
  input  logic              rx_vld,
  input  logic              rx_fs,
  input  logic [W-1:0]      tx_byte,
  input  logic [W-1:0]      tx_sig,
  input  logic              tx_vld,
  input  logic              tx_sync,
  input  logic              tx_mfs,
  input  logic              ctrl_wr,
  input  logic              ctrl_loop,
  input  logic              ctrl_ts0_thru,
  input  logic              ais_force,
  output logic [W-1:0]      out_byte,
  output logic              out_vld,
  output logic [SLOT_W-1:0] out_ts,
  output logic              out_mfs,
  output logic              slip_rep,
  output logic              slip_drop
);
  logic              loop_q;
  logic              thru_q;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  wr_next;
  logic [PTR_W-1:0]  rd_addr;
  logic [SLOT_W-1:0] rd_slot;
  logic [W-1:0]      buf_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      thru_q <= 1'b0;
    end else if (ctrl_wr) begin
      loop_q <= ctrl_loop;
      thru_q <= ctrl_ts0_thru;
    end
  end

  plt_wr_ctl #(.FRAME_SLOTS(FRAME_SLOTS), .DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_fs(rx_fs),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_ptr(wr_ptr), .wr_next(wr_next)
  );

  plt_buf #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(rx_byte), .rd_addr(rd_addr), .rd_data(buf_byte)
  );

  plt_rd_ctl #(.FRAME_SLOTS(FRAME_SLOTS), .DEPTH(DEPTH), .GUARD(GUARD)) u_rd (
    .clk(clk), .rst_n(rst_n), .tx_vld(tx_vld), .ctrl_wr(ctrl_wr),
    .wr_ptr(wr_ptr), .wr_next(wr_next), .rd_addr(rd_addr), .rd_slot(rd_slot),
    .slip_rep(slip_rep), .slip_drop(slip_drop)
  );

  plt_tx_mux #(
    .W(W), .FRAME_SLOTS(FRAME_SLOTS), .SIG_SLOT(SIG_SLOT),
    .FAS_WORD(FAS_WORD), .NFAS_WORD(NFAS_WORD)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .tx_vld(tx_vld), .tx_byte(tx_byte), .tx_sig(tx_sig),
    .tx_sync(tx_sync), .tx_mfs(tx_mfs), .ais_force(ais_force), .loop_q(loop_q),
    .thru_q(thru_q), .buf_byte(buf_byte), .rd_slot(rd_slot), .out_byte(out_byte),
    .out_vld(out_vld), .out_ts(out_ts), .out_mfs(out_mfs)
  );

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(loop_q) && $stable(thru_q)));

endmodule

// File: tb/payload_loop_tx_test.sv
module payload_loop_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0, tx_byte = '0, tx_sig = '0;
  logic       rx_vld = 0, rx_fs = 0, tx_vld = 0, tx_sync = 0, tx_mfs = 0;
  logic       ctrl_wr = 0, ctrl_loop = 0, ctrl_ts0_thru = 0, ais_force = 0;
  logic [7:0] out_byte;
  logic       out_vld, out_mfs, slip_rep, slip_drop;
  logic [4:0] out_ts;

  payload_loop_tx uut (.*);

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, rx_cnt = 0, tx_cnt = 0;
  int rx_win = 32, tx_win = 32;
  bit scramble = 0, ais_mode = 0, bump_fs = 0, gen_phase = 0, ais_phase = 0, done = 0;
  int fas_seen = 0, nfas_seen = 0, ff_seen = 0, rep_seen = 0, drop_seen = 0;
  string tag = "R9";

  // behavioural reference
  int mem [64];
  int wr, rd, ts, fpar;
  bit loop_m, thru_m;
  int e_vld, e_byte, e_ts, e_mfs, e_rep, e_drop;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      wr = 32; rd = 0; ts = 0; fpar = 0; loop_m = 0; thru_m = 0;
      e_vld = 0; e_byte = 0; e_ts = 0; e_mfs = 0; e_rep = 0; e_drop = 0;
    end else begin
      int wa, wn, rn, ra, d, slot, nslot, s, t;
      wa = wr;
      if (rx_fs && (wa % 32 != 0)) wa = ((wa / 32 + 1) * 32) % 64;
      wn = rx_vld ? (wa + 1) % 64 : wr;
      rn = rd;
      e_vld = 0; e_rep = 0; e_drop = 0;
      if (tx_vld) begin
        ra = rd;
        if (ra % 32 == 0) begin
          d = (wr - rd + 64) % 64;
          if (d < 2) begin ra = (ra + 32) % 64; e_rep = 1; end
          else if (d > 62) begin ra = (ra + 32) % 64; e_drop = 1; end
        end
        slot = ra % 32;
        nslot = tx_sync ? 0 : ts;
        ts = (nslot + 1) % 32;
        if (ais_force) e_byte = 255;
        else if (loop_m && !thru_m && slot == 0) e_byte = fpar ? 64 : 27;
        else if (loop_m) e_byte = mem[ra];
        else e_byte = (nslot == 16) ? int'(tx_sig) : int'(tx_byte);
        e_ts = loop_m ? slot : nslot;
        e_mfs = (!loop_m && tx_mfs) ? 1 : 0;
        if (slot == 0) fpar ^= 1;
        e_vld = 1;
        rn = (ra + 1) % 64;
      end
      if (rx_vld) mem[wa] = int'(rx_byte);
      wr = wn; rd = rn;
      if (ctrl_wr) begin
        loop_m = ctrl_loop; thru_m = ctrl_ts0_thru;
        s = ((wr - rd) % 32 + 32) % 32;
        t = (s < 16) ? s + 32 : s;
        rd = (wr - t + 64) % 64;
      end
    end
  end

  task automatic cmp(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check();
    cmp(tag, "out_vld", int'(out_vld), e_vld);
    cmp("R7", "slip_rep", int'(slip_rep), e_rep);
    cmp("R7", "slip_drop", int'(slip_drop), e_drop);
    if (e_vld != 0) begin
      cmp(tag, "out_byte", int'(out_byte), e_byte);
      cmp(tag, "out_ts", int'(out_ts), e_ts);
      cmp(tag, "out_mfs", int'(out_mfs), e_mfs);
    end
    if (out_vld && gen_phase && out_ts == 0) begin
      if (out_byte == 8'h1B) fas_seen++;
      if (out_byte == 8'h40) nfas_seen++;
    end
    if (out_vld && ais_phase && out_byte == 8'hFF) ff_seen++;
    if (slip_rep) rep_seen++;
    if (slip_drop) drop_seen++;
  endtask

  task automatic drive();
    int pr, pt;
    cyc++;
    pr = cyc % rx_win; pt = cyc % tx_win;
    ctrl_wr = 0;
    rx_vld = (pr % 4 == 0) && (pr + 4 <= rx_win);
    tx_vld = (pt % 4 == 0) && (pt + 4 <= tx_win);
    rx_byte = 8'($urandom);
    if (rx_vld) begin
      if (bump_fs && rx_cnt % 32 == 13) begin rx_fs = 1; rx_cnt = 0; bump_fs = 0; end
      else rx_fs = (rx_cnt % 32 == 0);
      rx_cnt++;
    end else rx_fs = 1'($urandom);
    tx_byte = 8'($urandom);
    tx_sig = 8'($urandom);
    if (scramble) begin
      tx_sync = ($urandom % 5 == 0);
      tx_mfs = ($urandom % 3 == 0);
    end else begin
      tx_sync = tx_vld && (tx_cnt % 32 == 0);
      tx_mfs = tx_sync && ((tx_cnt / 32) % 16 == 0);
    end
    if (tx_vld) tx_cnt++;
    ais_force = ais_mode && ($urandom % 4 == 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
      drive();
    end
  endtask

  task automatic ctrl(bit l, bit t);
    @(negedge clk);
    check();
    rx_vld = 0; tx_vld = 0; ais_force = 0;
    ctrl_wr = 1; ctrl_loop = l; ctrl_ts0_thru = t;
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state at the ports
    cmp("R9", "reset out_vld", int'(out_vld), 0);
    cmp("R9", "reset out_byte", int'(out_byte), 0);
    cmp("R9", "reset out_ts", int'(out_ts), 0);
    cmp("R9", "reset slips", int'(slip_rep) + int'(slip_drop), 0);

    tag = "R1"; run(1500);

    ctrl(1, 1); tag = "R2"; scramble = 1; run(1500);
    tag = "R3"; run(600);
    tag = "R8"; bump_fs = 1; run(1000);

    ctrl(1, 0); tag = "R4"; gen_phase = 1; run(1500); gen_phase = 0;
    cmp("R4", "alignment words seen", int'(fas_seen > 0), 1);
    cmp("R4", "non-alignment words seen", int'(nfas_seen > 0), 1);

    tag = "R5"; ais_mode = 1; ais_phase = 1; run(800);
    ctrl(0, 0); scramble = 0; run(800);
    ais_mode = 0; ais_phase = 0;
    cmp("R5", "all-ones bytes seen", int'(ff_seen > 0), 1);

    ctrl(1, 1); tag = "R7"; scramble = 1;
    rx_win = 32; tx_win = 33; run(6000);
    cmp("R7", "frame drop seen", int'(drop_seen > 0), 1);
    rx_win = 33; tx_win = 32; run(6000);
    cmp("R7", "frame repeat seen", int'(rep_seen > 0), 1);

    rx_win = 32; tx_win = 32;
    ctrl(1, 1); tag = "R6"; run(1500);
    ctrl(0, 1); run(600);

    done = 1;
    finish_up();
  end
endmodule